// File: doc/BRIEF.md
# Sequential Integer Divider with Zero-Divisor Trap

This block divides one 32-bit integer by another over a fixed number of clock cycles, for use as the divide unit of a small processor core. The core presents a dividend, a divisor and a signed/unsigned select together with a one-cycle start pulse. The block raises busy while it works and returns the quotient with a one-cycle done pulse. The quotient then stays on its output until the next division finishes.

A zero divisor takes a short path. No iterations run, the quotient is zero, and done arrives in the cycle after start. The block keeps a sticky divide-by-zero flag for the core's status register and pulses set and clear strobes so that the core can mirror the flag. A trap request is raised only when the core's exception enable is on and the divide-zero trap suppress input is off. When the trap fires, a cause code output is loaded with the divide-by-zero code.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (is_signed=0), with a nonzero divisor, the quotient equals floor(dividend / divisor), both operands taken as unsigned 32-bit values.
- R2: In signed mode (is_signed=1), both operands are two's complement. The quotient is truncated toward zero, so its magnitude is |dividend| / |divisor| and it is negative when the operand signs differ.
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns 0x80000000. No trap is raised and the divide-by-zero flag is cleared.
- R4: A start with a nonzero divisor, sampled when busy is low, sets busy from the next cycle for exactly 32 cycles. Done is high for one cycle, in the cycle after busy falls (33 cycles after start), with the new quotient on the output. The quotient then holds until the next completion.
- R5: A start with a zero divisor leaves busy low. It gives done and a quotient of 0 in the cycle after start.
- R6: A zero-divisor division sets dz_flag and pulses dz_set together with done. A nonzero-divisor division clears dz_flag and pulses dz_clr together with done. dz_flag holds its value between divisions.
- R7: trap_req pulses together with done only for a zero divisor, and only when exc_enable=1 and dz_trap_mask=0 in that cycle.
- R8: When trap_req pulses, cause holds the code 5'h05. The code stays until the next trap. Reset clears cause to 0.
- R9: A start received while busy is high has no effect. The running division completes with its original operands and timing.
- R10: Synchronous active-high reset clears busy, done, quotient, dz_flag, dz_set, dz_clr and trap_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when busy is low |
| is_signed | input | 1 | 1 selects two's complement operands, 0 unsigned |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| exc_enable | input | 1 | Global exception enable from the core |
| dz_trap_mask | input | 1 | 1 suppresses the divide-zero trap |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last completed division |
| dz_flag | output | 1 | Sticky divide-by-zero status |
| dz_set | output | 1 | Pulse: status bit set |
| dz_clr | output | 1 | Pulse: status bit cleared |
| trap_req | output | 1 | Divide-by-zero trap request pulse |
| cause | output | 5 | Exception cause code of the last trap |

## Verification
The bound checker watches several rules on every cycle. It checks the trap gating against the two enables and the one-cycle width of done. It checks that done never appears during busy and that set and clear never pulse together. It also checks the 32-cycle busy window, the zero-divisor early completion and the cause code presented with a trap. Only the bench scenarios can show that the quotient values are right in both modes, including the most-negative-over-minus-one case. The same applies to the sticky flag holding between divisions and to a start issued mid-division being ignored.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = 5'h05
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_signed,
  input  logic [W-1:0]       dividend,
  input  logic [W-1:0]       divisor,
  input  logic               exc_enable,
  input  logic               dz_trap_mask,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       quotient,
  output logic               dz_flag,
  output logic               dz_set,
  output logic               dz_clr,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] cause
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     rem, acc, dvs;
  logic             neg;

  logic         a_neg, b_neg, go, zero_div, fits;
  logic [W-1:0] a_mag, b_mag, next_rem, next_acc, final_q;
  logic [W:0]   trial;

  assign a_neg    = is_signed & dividend[W-1];
  assign b_neg    = is_signed & divisor[W-1];
  assign a_mag    = a_neg ? (~dividend + 1'b1) : dividend;
  assign b_mag    = b_neg ? (~divisor + 1'b1) : divisor;
  assign go       = start & ~busy;
  assign zero_div = (divisor == '0);

  assign trial    = {rem, acc[W-1]} - {1'b0, dvs};
  assign fits     = ~trial[W];
  assign next_rem = fits ? trial[W-1:0] : {rem[W-2:0], acc[W-1]};
  assign next_acc = {acc[W-2:0], fits};
  assign final_q  = neg ? (~next_acc + 1'b1) : next_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
      dz_flag  <= 1'b0;
      dz_set   <= 1'b0;
      dz_clr   <= 1'b0;
      trap_req <= 1'b0;
      cause    <= '0;
      cnt      <= '0;
      rem      <= '0;
      acc      <= '0;
      dvs      <= '0;
      neg      <= 1'b0;
    end else begin
      done     <= 1'b0;
      dz_set   <= 1'b0;
      dz_clr   <= 1'b0;
      trap_req <= 1'b0;
      if (go) begin
        if (zero_div) begin
          done     <= 1'b1;
          quotient <= '0;
          dz_flag  <= 1'b1;
          dz_set   <= 1'b1;
          if (exc_enable && !dz_trap_mask) begin
            trap_req <= 1'b1;
            cause    <= CAUSE_DIVZERO;
          end
        end else begin
          busy <= 1'b1;
          cnt  <= '0;
          rem  <= '0;
          acc  <= a_mag;
          dvs  <= b_mag;
          neg  <= a_neg ^ b_neg;
        end
      end else if (busy) begin
        rem <= next_rem;
        acc <= next_acc;
        cnt <= cnt + CNT_W'(1);
        if (cnt == LAST) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          quotient <= final_q;
          dz_flag  <= 1'b0;
          dz_clr   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/int_divider_checker.sv
module int_divider_checker #(
  parameter int W = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = 5'h05
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [W-1:0]       divisor,
  input logic               exc_enable,
  input logic               dz_trap_mask,
  input logic               busy,
  input logic               done,
  input logic [W-1:0]       quotient,
  input logic               dz_flag,
  input logic               dz_set,
  input logic               dz_clr,
  input logic               trap_req,
  input logic [CAUSE_W-1:0] cause
);
  logic [15:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else              bcnt <= bcnt + 16'd1;
  end

  p_trap_gate_r7: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($past(exc_enable) && !$past(dz_trap_mask) && done && dz_set));

  p_trap_result_r5: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (quotient == '0 && dz_flag));

  p_cause_code_r8: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> cause == CAUSE_DIVZERO);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
    (done && bcnt != 16'd0) |-> bcnt == 16'(W));

  p_set_clr_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(dz_set && dz_clr));

  p_zero_fast_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && !busy && quotient == '0));
endmodule

bind int_divider int_divider_checker #(.W(W), .CAUSE_W(CAUSE_W), .CAUSE_DIVZERO(CAUSE_DIVZERO)) chk (
  .clk(clk), .rst(rst), .start(start), .divisor(divisor),
  .exc_enable(exc_enable), .dz_trap_mask(dz_trap_mask), .busy(busy),
  .done(done), .quotient(quotient), .dz_flag(dz_flag), .dz_set(dz_set),
  .dz_clr(dz_clr), .trap_req(trap_req), .cause(cause)
);

// File: tb/int_divider_test.sv
`timescale 1ns/1ps
module int_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        exc_enable = 1'b0;
  logic        dz_trap_mask = 1'b0;
  logic        busy, done, dz_flag, dz_set, dz_clr, trap_req;
  logic [31:0] quotient;
  logic [4:0]  cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [4:0] exp_cause = 5'h00;

  always #4 clk = ~clk;

  int_divider uut (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .exc_enable(exc_enable),
    .dz_trap_mask(dz_trap_mask), .busy(busy), .done(done),
    .quotient(quotient), .dz_flag(dz_flag), .dz_set(dz_set),
    .dz_clr(dz_clr), .trap_req(trap_req), .cause(cause)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_q(input logic [31:0] a, input logic [31:0] b, input bit sgn);
    if (b == 0) return 32'h0;
    if (!sgn) return a / b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
    return 32'($signed(a) / $signed(b));
  endfunction

  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                         input bit ee, input bit mask, input bit inject);
    int cyc;
    bit exp_trap;
    logic [31:0] eq;
    eq = model_q(a, b, sgn);
    exp_trap = (b == 0) && ee && !mask;
    @(negedge clk);
    dividend = a; divisor = b; is_signed = sgn;
    exc_enable = ee; dz_trap_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == (b != 0), (b == 0) ? "R5 busy" : "R4 busy", busy, b != 0);
    while (!done && cyc < 100) begin
      if (inject && cyc == 5) begin
        dividend = ~a; divisor = 32'h3; is_signed = ~sgn; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (b == 0) check(cyc == 1, "R5 latency", cyc, 1);
    else check(cyc == 33, inject ? "R9 latency" : "R4 latency", cyc, 33);
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF && sgn)
      check(quotient == 32'h8000_0000 && !trap_req && !dz_flag, "R3 overflow case", quotient, 32'h8000_0000);
    else if (inject)
      check(quotient == eq, "R9 quotient", quotient, eq);
    else
      check(quotient == eq, sgn ? "R2 signed quotient" : "R1 unsigned quotient", quotient, eq);
    check(dz_flag == (b == 0) && dz_set == (b == 0) && dz_clr == (b != 0), "R6 status",
          {dz_flag, dz_set, dz_clr}, {b == 0, b == 0, b != 0});
    check(trap_req == exp_trap, "R7 trap", trap_req, exp_trap);
    if (exp_trap) exp_cause = 5'h05;
    check(cause == exp_cause, "R8 cause", cause, exp_cause);
    @(negedge clk);
    check(!done && quotient == eq, "R4 pulse/hold", {done, quotient}, {1'b0, eq});
    check(dz_flag == (b == 0), "R6 sticky", dz_flag, b == 0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && quotient == 0 && !dz_flag && !dz_set && !dz_clr && !trap_req && cause == 0,
          "R10 reset", {busy, done, dz_flag, trap_req}, 0);
    run_div(32'd100, 32'd7, 0, 1, 0, 0);
    run_div(32'hFFFF_FFFF, 32'd1, 0, 1, 0, 0);
    run_div(32'd5, 32'd9, 0, 0, 0, 0);
    run_div(-32'sd100, 32'd7, 1, 1, 0, 0);
    run_div(32'd100, -32'sd7, 1, 1, 0, 0);
    run_div(-32'sd7, -32'sd2, 1, 1, 0, 0);
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, 0);
    run_div(32'd42, 32'd0, 0, 1, 1, 0);
    run_div(32'd42, 32'd0, 0, 0, 0, 0);
    run_div(32'd42, 32'd0, 1, 1, 0, 0);
    run_div(32'd77, 32'd0, 0, 0, 1, 0);
    run_div(32'd1000, 32'd10, 0, 1, 0, 1);
    run_div(-32'sd999, 32'd4, 1, 1, 0, 1);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      case ($urandom_range(0, 3))
        0: b = 32'h0;
        1: b = $urandom_range(1, 20);
        2: b = -$urandom_range(1, 20);
        default: b = $urandom();
      endcase
      run_div(a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'(i % 23 == 0));
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && quotient == 0 && !dz_flag && cause == 0, "R10 reset again",
          {busy, done, dz_flag}, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule